// File: doc/BRIEF.md
# GPIO Pin Drive and Pull Resolver

This block decides, for every pin of a general-purpose I/O port, whether the pad is actively driven and at what level. It also decides what value the pin's input bit reads back. Each pin has a small configuration word, an output-latch bit and an external stimulus (a valid flag plus a level). The configuration word selects:

- the direction,
- whether the input buffer is cut off,
- the pull resistor,
- a drive mode.

Some drive modes connect the driver for only one logic level, in the style of open-drain or open-source outputs.

All results are registered. The block reports the following once per clock:

- the pad drive, as an enable plus a level;
- the resolved input bits;
- a per-pin contention flag, set when the internal driver and an external driver disagree;
- a one-cycle change event whenever a pin's driven state or level differs from the previous cycle.

Standard and high drive strengths are treated the same. A register bus, if one is needed, sits outside this block.

Top module: `gpio_pin_resolver`

## Requirements
- R1: With direction = 1 and drive mode 0 to 3, the pin is driven one clock later (padEn = 1) at the output-latch level.
- R2: Drive modes 4 and 5 connect the driver only while the latch bit is 1. Modes 6 and 7 connect it only while the latch bit is 0. When disconnected, and no pull takes over, padEn is 0 and padLevel still shows the latch bit.
- R3: With direction = 0 and no pull enabled, the pin is never driven.
- R4: Pull field encodings: 2'b01 is pull-down (value 0), 2'b11 is pull-up (value 1), and 2'b00 and 2'b10 mean no pull. With the input buffer cut off and a pull enabled, the input bit takes the pull value, whatever the external stimulus.
- R5: With the buffer connected, no valid external stimulus, the driver disconnected and a pull enabled, the pin counts as driven at the pull level. padEn = 1, padLevel = pull value, and the input bit = pull value.
- R6: With the buffer connected and a valid external stimulus, the input bit takes the external level.
- R7: shortFlag for a pin is 1 exactly when the buffer is connected, the external stimulus is valid, the driver is connected and the two levels differ. A cut-off buffer never raises it.
- R8: With the buffer connected, no valid external stimulus and the driver connected, the input bit follows the driven level.
- R9: When no rule above gives the input bit a value, it holds its previous value. With the buffer cut off and no pull, a valid stimulus still loads its level.
- R10: changeEvt for a pin is high for exactly the cycle in which padEn or padLevel takes a new value, and it is low otherwise.
- R11: A synchronous active-high reset clears padEn, padLevel, inBits, shortFlag and changeEvt.
- R12: Pins are independent. Pin i uses cfgFlat[7i+6:7i], laid out as: bit 0 direction (1 = output), bit 1 input buffer off, bits [3:2] pull, bits [6:4] drive mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgFlat | input | NUM_PINS*7 | Per-pin configuration words, packed |
| outLatch | input | NUM_PINS | Output latch bits |
| extValid | input | NUM_PINS | External stimulus present |
| extLevel | input | NUM_PINS | External stimulus level |
| padEn | output | NUM_PINS | Pad actively driven |
| padLevel | output | NUM_PINS | Resolved drive level |
| inBits | output | NUM_PINS | Resolved input bits |
| shortFlag | output | NUM_PINS | Internal/external drive contention |
| changeEvt | output | NUM_PINS | One-cycle pulse on drive-state change |

## Verification
The stored per-pin state is the previous drive state and the input bit. A wrong stored drive state shows up on padEn or padLevel one clock after the stimulus. It also shows up as a missing or spurious changeEvt pulse in the same cycle, or one cycle later. A wrong held input bit only surfaces when a floating pin is read, so the stimulus deliberately alternates driven and floating states on the same pin. Contention and pull substitution are checked on the cycle right after the stimulus that should trigger them.

// File: rtl/gpio_res_pkg.sv
package gpio_res_pkg;

  // Per-pin configuration word layout
  localparam int CFG_W      = 7;
  localparam int DIR_POS    = 0;
  localparam int BUFOFF_POS = 1;
  localparam int PULL_LSB   = 2;
  localparam int PULL_W     = 2;
  localparam int DRV_LSB    = 4;
  localparam int DRV_W      = 3;

  localparam logic [PULL_W-1:0] PULL_DOWN = 2'b01;
  localparam logic [PULL_W-1:0] PULL_UP   = 2'b11;

  // Strobes handed from the decode side to the datapath, one per pin
  typedef struct packed {
    logic drvOn;    // driver connected (direction and drive mode agree)
    logic bufOff;   // input buffer cut off
    logic pullOn;   // a pull resistor is enabled
    logic pullLvl;  // level the pull resistor provides
  } pinStrobe_t;

  // Whether the drive mode lets the driver connect for this output level
  function automatic logic gateForMode(input logic [DRV_W-1:0] mode,
                                       input logic outBit);
    logic gate;
    case (mode)
      3'd0, 3'd1, 3'd2, 3'd3: gate = 1'b1;
      3'd4, 3'd5:             gate = outBit;
      default:                gate = ~outBit;
    endcase
    return gate;
  endfunction

endpackage

// File: rtl/gpio_res_ctrl.sv
module gpio_res_ctrl
  import gpio_res_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic [NUM_PINS*CFG_W-1:0] cfgFlat,
  input  logic [NUM_PINS-1:0]       outLatch,
  output pinStrobe_t [NUM_PINS-1:0] strobe
);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_dec
    logic [CFG_W-1:0]  cfgWord;
    logic [DRV_W-1:0]  driveMode;
    logic [PULL_W-1:0] pullSel;
    logic              modeGate;

    assign cfgWord   = cfgFlat[i*CFG_W +: CFG_W];
    assign driveMode = cfgWord[DRV_LSB +: DRV_W];
    assign pullSel   = cfgWord[PULL_LSB +: PULL_W];
    assign modeGate  = gateForMode(driveMode, outLatch[i]);

    assign strobe[i] = '{
      drvOn:   cfgWord[DIR_POS] & modeGate,
      bufOff:  cfgWord[BUFOFF_POS],
      pullOn:  (pullSel == PULL_DOWN) || (pullSel == PULL_UP),
      pullLvl: (pullSel == PULL_UP)
    };
  end

endmodule

// File: rtl/gpio_res_dp.sv
module gpio_res_dp
  import gpio_res_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  pinStrobe_t [NUM_PINS-1:0] strobe,
  input  logic [NUM_PINS-1:0]       outLatch,
  input  logic [NUM_PINS-1:0]       extValid,
  input  logic [NUM_PINS-1:0]       extLevel,
  output logic [NUM_PINS-1:0]       padEn,
  output logic [NUM_PINS-1:0]       padLevel,
  output logic [NUM_PINS-1:0]       inBits,
  output logic [NUM_PINS-1:0]       shortFlag,
  output logic [NUM_PINS-1:0]       changeEvt
);

  logic [NUM_PINS-1:0] connQ, lvlQ, inQ, shortQ, evtQ;
  logic [NUM_PINS-1:0] connD, lvlD, inD, shortD;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic conn, lvl, inNext, clash;

    always_comb begin
      conn   = strobe[i].drvOn;
      lvl    = outLatch[i];
      inNext = inQ[i];
      clash  = 1'b0;
      if (strobe[i].bufOff) begin
        // Buffer cut off: pull wins, else a present stimulus loads
        if (strobe[i].pullOn) begin
          inNext = strobe[i].pullLvl;
        end else if (extValid[i]) begin
          inNext = extLevel[i];
        end
      end else if (extValid[i]) begin
        inNext = extLevel[i];
        clash  = conn & (lvl ^ extLevel[i]);
      end else begin
        // Floating pin: the pull acts as a driver when the output is off
        if (strobe[i].pullOn && !conn) begin
          conn = 1'b1;
          lvl  = strobe[i].pullLvl;
        end
        if (conn) begin
          inNext = lvl;
        end
      end
    end

    assign connD[i]  = conn;
    assign lvlD[i]   = lvl;
    assign inD[i]    = inNext;
    assign shortD[i] = clash;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      connQ  <= '0;
      lvlQ   <= '0;
      inQ    <= '0;
      shortQ <= '0;
      evtQ   <= '0;
    end else begin
      connQ  <= connD;
      lvlQ   <= lvlD;
      inQ    <= inD;
      shortQ <= shortD;
      evtQ   <= (connD ^ connQ) | (lvlD ^ lvlQ);
    end
  end

  assign padEn     = connQ;
  assign padLevel  = lvlQ;
  assign inBits    = inQ;
  assign shortFlag = shortQ;
  assign changeEvt = evtQ;

endmodule

// File: rtl/gpio_pin_resolver.sv
module gpio_pin_resolver
  import gpio_res_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_PINS*CFG_W-1:0] cfgFlat,
  input  logic [NUM_PINS-1:0]       outLatch,
  input  logic [NUM_PINS-1:0]       extValid,
  input  logic [NUM_PINS-1:0]       extLevel,
  output logic [NUM_PINS-1:0]       padEn,
  output logic [NUM_PINS-1:0]       padLevel,
  output logic [NUM_PINS-1:0]       inBits,
  output logic [NUM_PINS-1:0]       shortFlag,
  output logic [NUM_PINS-1:0]       changeEvt
);

  pinStrobe_t [NUM_PINS-1:0] strobe;

  gpio_res_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .cfgFlat  (cfgFlat),
    .outLatch (outLatch),
    .strobe   (strobe)
  );

  gpio_res_dp #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .outLatch  (outLatch),
    .extValid  (extValid),
    .extLevel  (extLevel),
    .padEn     (padEn),
    .padLevel  (padLevel),
    .inBits    (inBits),
    .shortFlag (shortFlag),
    .changeEvt (changeEvt)
  );

endmodule

// File: rtl/gpio_pin_resolver_chk.sv
module gpio_pin_resolver_chk
  import gpio_res_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_PINS*CFG_W-1:0] cfgFlat,
  input logic [NUM_PINS-1:0]       outLatch,
  input logic [NUM_PINS-1:0]       extValid,
  input logic [NUM_PINS-1:0]       extLevel,
  input logic [NUM_PINS-1:0]       padEn,
  input logic [NUM_PINS-1:0]       padLevel,
  input logic [NUM_PINS-1:0]       inBits,
  input logic [NUM_PINS-1:0]       shortFlag,
  input logic [NUM_PINS-1:0]       changeEvt
);

  logic [NUM_PINS-1:0] dirV, bufOffV, pullOnV, pullLvlV, modeAll, modeHiOnly;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_fld
    logic [DRV_W-1:0] m;
    assign m             = cfgFlat[i*CFG_W + DRV_LSB +: DRV_W];
    assign dirV[i]       = cfgFlat[i*CFG_W + DIR_POS];
    assign bufOffV[i]    = cfgFlat[i*CFG_W + BUFOFF_POS];
    assign pullOnV[i]    = cfgFlat[i*CFG_W + PULL_LSB];
    assign pullLvlV[i]   = cfgFlat[i*CFG_W + PULL_LSB + 1];
    assign modeAll[i]    = (m < 3'd4);
    assign modeHiOnly[i] = (m == 3'd4) || (m == 3'd5);
  end

  AST_ALWAYS_MODES_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (((~padEn) | (padLevel ^ $past(outLatch))) & $past(dirV & modeAll)) == '0); // R1

  AST_HIGH_ONLY_MODES_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((~padEn) & $past(dirV & modeHiOnly & outLatch)) == '0); // R2

  AST_NO_DIR_NO_PULL_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (padEn & $past(~dirV & ~pullOnV)) == '0); // R3

  AST_BUFOFF_PULL_WINS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((inBits ^ $past(pullLvlV)) & $past(bufOffV & pullOnV)) == '0); // R4

  AST_EXT_LOADS_IN: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((inBits ^ $past(extLevel)) & $past(extValid & ~bufOffV)) == '0); // R6

  AST_SHORT_NEEDS_EXT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (shortFlag & $past(~extValid | bufOffV)) == '0); // R7

  AST_EVT_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> changeEvt == ((padEn ^ $past(padEn)) | (padLevel ^ $past(padLevel)))); // R10

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (padEn == '0 && padLevel == '0 && inBits == '0 &&
                    shortFlag == '0 && changeEvt == '0)); // R11

endmodule

bind gpio_pin_resolver gpio_pin_resolver_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfgFlat   (cfgFlat),
  .outLatch  (outLatch),
  .extValid  (extValid),
  .extLevel  (extLevel),
  .padEn     (padEn),
  .padLevel  (padLevel),
  .inBits    (inBits),
  .shortFlag (shortFlag),
  .changeEvt (changeEvt)
);

// File: tb/gpio_pin_resolver_bench.sv
module gpio_pin_resolver_bench;
  import gpio_res_pkg::*;

  localparam int NUM_PINS = 32;
  localparam int TP       = 9;   // pin walked by the vector table
  localparam int NVEC     = 20;

  typedef struct packed {
    logic [3:0] req;
    logic [2:0] drv;
    logic [1:0] pull;
    logic       bufOff;
    logic       dir;
    logic       outB;
    logic       extV;
    logic       extL;
    logic       eEn;
    logic       eLvl;
    logic       eIn;
    logic       eSh;
  } vec_t;

  // req, drv, pull, bufOff, dir, out, extV, extL -> en, lvl, in, short
  localparam vec_t VECS [NVEC] = '{
    '{4'd1, 3'd0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R1 R8
    '{4'd1, 3'd0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R1
    '{4'd2, 3'd4, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R2
    '{4'd2, 3'd4, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R2 hold
    '{4'd2, 3'd6, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R2
    '{4'd2, 3'd7, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R2
    '{4'd5, 3'd0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R5 pull-up
    '{4'd5, 3'd3, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 pull-down
    '{4'd3, 3'd0, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 no pull
    '{4'd7, 3'd0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}, // R7 clash
    '{4'd6, 3'd0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R6 agree
    '{4'd7, 3'd4, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 driver off
    '{4'd6, 3'd0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R6
    '{4'd4, 3'd0, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 down
    '{4'd4, 3'd0, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 up
    '{4'd4, 3'd0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R4 no clash
    '{4'd9, 3'd0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R9 load
    '{4'd9, 3'd0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R9 hold
    '{4'd9, 3'd0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R9 hold
    '{4'd2, 3'd5, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}  // R2
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_PINS*CFG_W-1:0] cfgFlat = '0;
  logic [NUM_PINS-1:0] outLatch = '0, extValid = '0, extLevel = '0;
  logic [NUM_PINS-1:0] padEn, padLevel, inBits, shortFlag, changeEvt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  gpio_pin_resolver #(.NUM_PINS(NUM_PINS)) u_gpio_pin_resolver (
    .clk, .rst, .cfgFlat, .outLatch, .extValid, .extLevel,
    .padEn, .padLevel, .inBits, .shortFlag, .changeEvt
  );

  function automatic logic [CFG_W-1:0] mk(input logic [2:0] d, input logic [1:0] p,
                                          input logic b, input logic r);
    return {d, p, b, r};
  endfunction

  task automatic chk(input int req, input string what,
                     input logic [NUM_PINS-1:0] act, input logic [NUM_PINS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : wd
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [NUM_PINS-1:0] one, exp31;
    logic prevEn, prevLvl;
    one = '0;
    one[TP] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: state after reset
    chk(11, "padEn reset", padEn, '0);
    chk(11, "padLevel reset", padLevel, '0);
    chk(11, "inBits reset", inBits, '0);
    chk(11, "shortFlag reset", shortFlag, '0);
    chk(11, "changeEvt reset", changeEvt, '0);
    rst = 1'b0;

    prevEn = 1'b0;
    prevLvl = 1'b0;
    for (int v = 0; v < NVEC; v++) begin
      cfgFlat[TP*CFG_W +: CFG_W] = mk(VECS[v].drv, VECS[v].pull, VECS[v].bufOff, VECS[v].dir);
      outLatch[TP] = VECS[v].outB;
      extValid[TP] = VECS[v].extV;
      extLevel[TP] = VECS[v].extL;
      step();
      chk(VECS[v].req, $sformatf("row %0d padEn", v), padEn, VECS[v].eEn ? one : '0);
      chk(VECS[v].req, $sformatf("row %0d padLevel", v), padLevel, VECS[v].eLvl ? one : '0);
      chk(VECS[v].req, $sformatf("row %0d inBits", v), inBits, VECS[v].eIn ? one : '0);
      chk(VECS[v].req, $sformatf("row %0d shortFlag", v), shortFlag, VECS[v].eSh ? one : '0);
      // R10: pulse exactly when the drive state moved
      chk(10, $sformatf("row %0d changeEvt", v), changeEvt,
          ((VECS[v].eEn != prevEn) || (VECS[v].eLvl != prevLvl)) ? one : '0);
      step();
      chk(10, $sformatf("row %0d changeEvt second cycle", v), changeEvt, '0);
      prevEn = VECS[v].eEn;
      prevLvl = VECS[v].eLvl;
    end

    // R11: reset in the middle of activity clears everything
    rst = 1'b1;
    step();
    chk(11, "padEn mid reset", padEn, '0);
    chk(11, "inBits mid reset", inBits, '0);
    chk(11, "changeEvt mid reset", changeEvt, '0);

    // R12: independent pins at both ends of the port
    cfgFlat = '0;
    outLatch = '0;
    extValid = '0;
    extLevel = '0;
    cfgFlat[31*CFG_W +: CFG_W] = mk(3'd0, 2'b00, 1'b0, 1'b1);
    outLatch[31] = 1'b1;
    cfgFlat[0 +: CFG_W] = mk(3'd0, 2'b11, 1'b0, 1'b0);
    extValid[1] = 1'b1;
    extLevel[1] = 1'b1;
    rst = 1'b0;
    step();
    exp31 = '0;
    exp31[31] = 1'b1;
    exp31[0] = 1'b1;
    chk(12, "padEn multi-pin", padEn, exp31);
    chk(12, "padLevel multi-pin", padLevel, exp31);
    chk(12, "inBits multi-pin", inBits, exp31 | 32'h2);
    chk(12, "changeEvt multi-pin", changeEvt, exp31);
    chk(12, "shortFlag multi-pin", shortFlag, '0);

    // R7: contention on pin 31 only
    extValid[31] = 1'b1;
    extLevel[31] = 1'b0;
    step();
    chk(7, "shortFlag pin31", shortFlag, 32'h8000_0000);
    chk(6, "inBits pin31 follows ext", inBits, 32'h0000_0003);
    chk(10, "changeEvt no drive change", changeEvt, '0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule